// File: doc/BRIEF.md
# Interleaved Turn-by-Turn Bunch Feedback FIR

This block filters beam-position samples for a ring with many bunch slots. Each slot gets its own 32-tap FIR whose taps lie one full machine turn apart. Upstream logic delivers one DC-removed sample per cycle, tagged with its slot number. The block multiplies that sample, and the same slot's samples from the previous 31 turns, by 32 coefficients that all slots share. It adds the products, scales the sum down by a selectable power of two, and saturates the result to the signed 14-bit range a DAC expects.

A control processor programs the coefficients and the scale select through a small write-only register port. Writes land in a shadow set. The shadow set becomes active only when the sample for slot 0 arrives, so every output of a turn uses one consistent coefficient set. The slot count is the parameter `NSLOTS`. A ring with 324 slots sets it to 324. The default is smaller to keep the history storage modest.

Top module: `ifir_bunch_fir`

## Requirements
- R1: After reset, `out_valid` is 0 and `out_data` is 0. All coefficients, the scale select and every slot's history are zero, so the first outputs after reset are 0.
- R2: Each cycle with `in_valid` high produces exactly one cycle with `out_valid` high, four clock cycles later. Outputs come in input order, and no other output cycles occur.
- R3: The output for a sample of slot s sums tap products. Tap 0 is the current sample times coefficient 0. Tap n (1 to 31) is the sample slot s received n turns earlier times coefficient n.
- R4: Every slot keeps its own history. A sample for one slot never enters the taps of another slot.
- R5: The register map is as follows. Address 0 to 31 writes coefficient n as the signed 18-bit `cfg_wdata`. Address 32 writes the scale select from `cfg_wdata[1:0]`, and higher data bits are ignored. Writes to addresses 33 to 63 have no effect.
- R6: Written values take effect with the next valid sample whose slot is 0. Outputs for samples before that one use the previous set, and outputs from that one onward use the new set.
- R7: The product sum is shifted right arithmetically (rounding toward minus infinity) by 12 + 2*sel bits, where sel is the scale select (0 to 3).
- R8: A scaled value above 8191 gives 8191, and a value below -8192 gives -8192. The output never wraps.
- R9: The product sum is exact for any inputs, including 32 full-scale products. The result does not depend on the order in which the partial sums are formed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_slot | input | SLOT_W | Bunch slot of the sample, 0 to NSLOTS-1 |
| in_sample | input | 16 | Signed DC-removed sample |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register address |
| cfg_wdata | input | 18 | Register write data |
| out_valid | output | 1 | Filtered result is present |
| out_data | output | 14 | Signed, scaled and saturated result |

## Verification
The assertions assume the following about the inputs:
- `in_slot` always lies below `NSLOTS` when `in_valid` is high.
- Slot 0 marks the start of each turn, and slots arrive in increasing order.

The coefficient-hold property also assumes that a turn boundary is the only cause of a change to the active set. The stimulus steps through the slots in order, turn after turn, with gaps only where it performs register writes. It never issues a write in the same cycle as a slot-0 sample, so the expected switchover point stays unambiguous.

// File: rtl/ifir_pkg.sv
package ifir_pkg;
  localparam int NTAPS      = 32;
  localparam int SAMPLE_W   = 16;
  localparam int COEF_W     = 18;
  localparam int OUT_W      = 14;
  localparam int SCALE_W    = 2;
  localparam int SCALE_BASE = 12;
  localparam int SCALE_STEP = 2;
  localparam int PROD_W     = SAMPLE_W + COEF_W;
  localparam int ACC_W      = PROD_W + $clog2(NTAPS);
  localparam int CFG_AW     = $clog2(NTAPS) + 1;
  localparam int OUT_MAX    = (1 << (OUT_W - 1)) - 1;
  localparam int OUT_MIN    = -(1 << (OUT_W - 1));

  typedef logic signed [SAMPLE_W-1:0] smp_t;
  typedef logic signed [COEF_W-1:0]   coef_t;
  typedef logic signed [PROD_W-1:0]   prod_t;
  typedef logic signed [ACC_W-1:0]    acc_t;
  typedef logic signed [OUT_W-1:0]    out_t;
  typedef logic [SCALE_W-1:0]         scale_t;

  // number of bits the accumulated sum is shifted down for a given select
  function automatic int shift_of(scale_t sel);
    return SCALE_BASE + SCALE_STEP * int'(sel);
  endfunction

  function automatic acc_t scaled(acc_t a, scale_t sel);
    return a >>> shift_of(sel);
  endfunction

  function automatic logic over_hi(acc_t a, scale_t sel);
    return scaled(a, sel) > acc_t'(OUT_MAX);
  endfunction

  function automatic logic over_lo(acc_t a, scale_t sel);
    return scaled(a, sel) < acc_t'(OUT_MIN);
  endfunction

  // scale then clamp into the signed output range
  function automatic out_t clamp(acc_t a, scale_t sel);
    acc_t s;
    s = scaled(a, sel);
    if (s > acc_t'(OUT_MAX)) return out_t'(OUT_MAX);
    if (s < acc_t'(OUT_MIN)) return out_t'(OUT_MIN);
    return out_t'(s);
  endfunction
endpackage

// File: rtl/ifir_coef_bank.sv
module ifir_coef_bank
  import ifir_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [COEF_W-1:0]       cfg_wdata,
  input  logic                    turn_load,
  output coef_t [NTAPS-1:0]       act_coef,
  output scale_t                  act_scale
);
  coef_t [NTAPS-1:0] shd_coef;
  scale_t            shd_scale;
  logic              addr_is_coef;
  logic              addr_is_scale;

  assign addr_is_coef  = int'(cfg_addr) < NTAPS;
  assign addr_is_scale = int'(cfg_addr) == NTAPS;

  // shadow set: written by the control port at any time
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_coef  <= '0;
      shd_scale <= '0;
    end else if (cfg_we) begin
      if (addr_is_coef)  shd_coef[cfg_addr[CFG_AW-2:0]] <= coef_t'(cfg_wdata);
      if (addr_is_scale) shd_scale <= cfg_wdata[SCALE_W-1:0];
    end
  end

  // active set: copied only at the turn boundary
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_coef  <= '0;
      act_scale <= '0;
    end else if (turn_load) begin
      act_coef  <= shd_coef;
      act_scale <= shd_scale;
    end
  end

  assert_active_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !turn_load |=> ($stable(act_coef) && $stable(act_scale)));
endmodule

// File: rtl/ifir_history.sv
module ifir_history
  import ifir_pkg::*;
#(
  parameter int NSLOTS = 64,
  parameter int SLOT_W = $clog2(NSLOTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  access,
  input  logic [SLOT_W-1:0]     slot,
  input  smp_t                  sample,
  output smp_t [NTAPS-2:0]      past_row
);
  localparam int ROW_N = NTAPS - 1;

  // element j of a row holds the sample from j+1 turns earlier
  smp_t [ROW_N-1:0] mem [NSLOTS];
  logic             slot_ok;

  assign slot_ok  = int'(slot) < NSLOTS;
  assign past_row = slot_ok ? mem[slot] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NSLOTS; s++) mem[s] <= '0;
    end else if (access && slot_ok) begin
      mem[slot] <= {past_row[ROW_N-2:0], sample};
    end
  end

  assert_slot_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    access |-> slot_ok);
endmodule

// File: rtl/ifir_mac.sv
module ifir_mac
  import ifir_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tap_valid,
  input  smp_t [NTAPS-1:0]     taps,
  input  coef_t [NTAPS-1:0]    coef,
  input  scale_t               scale,
  output logic                 res_valid,
  output out_t                 res_data
);
  prod_t [NTAPS-1:0] prod_q;
  logic              prod_valid;
  scale_t            prod_scale;
  acc_t              acc_sum;
  acc_t              acc_q;
  logic              acc_valid;
  scale_t            acc_scale;
  logic              sat_hi_evt;
  logic              sat_lo_evt;

  // stage 1: one multiplier per tap
  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q[i] <= '0;
      else if (tap_valid) prod_q[i] <= $signed(taps[i]) * $signed(coef[i]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_valid <= 1'b0;
      prod_scale <= '0;
    end else begin
      prod_valid <= tap_valid;
      if (tap_valid) prod_scale <= scale;
    end
  end

  // stage 2: full-width sum of products
  always_comb begin
    acc_sum = '0;
    for (int i = 0; i < NTAPS; i++) acc_sum = acc_sum + acc_t'($signed(prod_q[i]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_q     <= '0;
      acc_scale <= '0;
    end else begin
      acc_valid <= prod_valid;
      if (prod_valid) begin
        acc_q     <= acc_sum;
        acc_scale <= prod_scale;
      end
    end
  end

  // stage 3: scale and saturate
  assign sat_hi_evt = acc_valid && over_hi(acc_q, acc_scale);
  assign sat_lo_evt = acc_valid && over_lo(acc_q, acc_scale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= acc_valid;
      if (acc_valid) res_data <= clamp(acc_q, acc_scale);
    end
  end

  assert_sat_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_hi_evt |=> (res_valid && res_data == out_t'(OUT_MAX)));
  assert_sat_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_lo_evt |=> (res_valid && res_data == out_t'(OUT_MIN)));
endmodule

// File: rtl/ifir_bunch_fir.sv
module ifir_bunch_fir
  import ifir_pkg::*;
#(
  parameter int NSLOTS = 64,
  parameter int SLOT_W = $clog2(NSLOTS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SLOT_W-1:0]    in_slot,
  input  logic [SAMPLE_W-1:0]  in_sample,
  input  logic                 cfg_we,
  input  logic [CFG_AW-1:0]    cfg_addr,
  input  logic [COEF_W-1:0]    cfg_wdata,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_data
);
  localparam int LATENCY = 4;

  logic              turn_load;
  coef_t [NTAPS-1:0] act_coef;
  scale_t            act_scale;
  smp_t [NTAPS-2:0]  hist_row;
  logic              s1_valid;
  smp_t [NTAPS-1:0]  s1_taps;
  out_t              res_data;

  assign turn_load = in_valid && (in_slot == '0);

  ifir_coef_bank u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .turn_load (turn_load),
    .act_coef  (act_coef),
    .act_scale (act_scale)
  );

  ifir_history #(.NSLOTS(NSLOTS), .SLOT_W(SLOT_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .access   (in_valid),
    .slot     (in_slot),
    .sample   (smp_t'(in_sample)),
    .past_row (hist_row)
  );

  // tap register: current sample at tap 0, history behind it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_taps  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) s1_taps <= {hist_row, smp_t'(in_sample)};
    end
  end

  ifir_mac u_mac (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_valid (s1_valid),
    .taps      (s1_taps),
    .coef      (act_coef),
    .scale     (act_scale),
    .res_valid (out_valid),
    .res_data  (res_data)
  );

  assign out_data = res_data;

  // edges seen since reset, for the latency check window
  logic [2:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (int'(since_rst) < LATENCY) since_rst <= since_rst + 3'd1;
  end

  assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(since_rst) == LATENCY) |-> (out_valid == $past(in_valid, 4)));
endmodule

// File: tb/ifir_bunch_fir_tb.sv
module ifir_bunch_fir_tb;
  import ifir_pkg::*;

  localparam int NS = 8;
  localparam int SW = $clog2(NS);

  typedef struct {
    int    exp;
    int    stamp;
    string tag;
  } item_t;

  logic                clk = 1'b0;
  logic                rst_n;
  logic                in_valid;
  logic [SW-1:0]       in_slot;
  logic [SAMPLE_W-1:0] in_sample;
  logic                cfg_we;
  logic [CFG_AW-1:0]   cfg_addr;
  logic [COEF_W-1:0]   cfg_wdata;
  logic                out_valid;
  logic [OUT_W-1:0]    out_data;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 0;
  int    m_hist [NS][NTAPS];
  int    sh_c [NTAPS];
  int    ac_c [NTAPS];
  int    sh_s = 0;
  int    ac_s = 0;
  item_t q [$];

  always #2 clk = ~clk;

  ifir_bunch_fir #(.NSLOTS(NS), .SLOT_W(SW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_slot(in_slot),
    .in_sample(in_sample), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .out_valid(out_valid), .out_data(out_data)
  );

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // driver: model the expected result, push it, then drive the sample
  task automatic send(int slot, int x, string tag);
    longint acc;
    longint s;
    int     taps [NTAPS];
    item_t  it;
    if (slot == 0) begin
      ac_c = sh_c;
      ac_s = sh_s;
    end
    taps[0] = x;
    for (int k = 1; k < NTAPS; k++) taps[k] = m_hist[slot][k-1];
    acc = 0;
    for (int k = 0; k < NTAPS; k++) acc += longint'(taps[k]) * longint'(ac_c[k]);
    s = acc >>> (12 + 2 * ac_s);
    if (s > 8191) s = 8191;
    if (s < -8192) s = -8192;
    it.exp = int'(s);
    it.stamp = cyc;
    it.tag = tag;
    q.push_back(it);
    for (int k = NTAPS - 2; k >= 1; k--) m_hist[slot][k] = m_hist[slot][k-1];
    m_hist[slot][0] = x;
    in_valid  = 1'b1;
    in_slot   = SW'(slot);
    in_sample = SAMPLE_W'(x);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic cfg_write(int addr, int data);
    int d;
    if (addr < NTAPS) begin
      d = data & 'h3FFFF;
      if (d >= 131072) d -= 262144;
      sh_c[addr] = d;
    end else if (addr == NTAPS) begin
      sh_s = data & 3;
    end
    cfg_we    = 1'b1;
    cfg_addr  = CFG_AW'(addr);
    cfg_wdata = COEF_W'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic int pattern(int mode, int s, int t);
    case (mode)
      0: return 1000 + 7 * s;
      1: return s * 200 + t * 5 - 300;
      2: return int'($urandom_range(0, 40000)) - 20000;
      3: return 32767;
      default: return -32768;
    endcase
  endfunction

  task automatic run_turn(int mode, int t, string tag);
    for (int s = 0; s < NS; s++) send(s, pattern(mode, s, t), tag);
  endtask

  // monitor: pop and compare as results appear
  always @(negedge clk) begin
    item_t it;
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R2 output without input", 1, 0);
      end else begin
        it = q.pop_front();
        check($signed(out_data) == it.exp, it.tag, $signed(out_data), it.exp);
        check(cyc == it.stamp + 4, "R2 latency", cyc, it.stamp + 4);
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_slot = '0; in_sample = '0;
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    for (int s = 0; s < NS; s++) for (int k = 0; k < NTAPS; k++) m_hist[s][k] = 0;
    for (int k = 0; k < NTAPS; k++) begin sh_c[k] = 0; ac_c[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    check(out_data == '0, "R1 out_data after reset", $signed(out_data), 0);
    run_turn(1, 0, "R1 zero coefficients after reset");

    // R3: tap 0 passes the current sample at unity gain
    cfg_write(0, 4096);
    cfg_write(NTAPS, 0);
    run_turn(0, 0, "R3 tap0 current sample");

    // R6: a mid-turn write waits for the next slot-0 sample
    for (int s = 0; s < NS; s++) begin
      if (s == 4) cfg_write(0, 8192);
      send(s, pattern(0, s, 0), "R6 old set until boundary");
    end
    run_turn(0, 0, "R6 new set after boundary");

    // R5: unmapped addresses and high scale bits are ignored
    cfg_write(40, 5000);
    cfg_write(63, -1);
    cfg_write(33, 1);
    cfg_write(NTAPS, 'h3FFFC);
    run_turn(0, 0, "R5 ignored writes");

    // R3/R4: delayed taps of the same slot only
    cfg_write(0, 0);
    cfg_write(1, 4096);
    for (int t = 0; t < 3; t++) run_turn(1, t, "R4 previous turn same slot");
    cfg_write(1, 0);
    cfg_write(31, 4096);
    for (int t = 3; t < 37; t++) run_turn(1, t, "R3 tap 31 turns back");
    cfg_write(31, 0);
    cfg_write(0, 2048);
    cfg_write(5, -4096);
    for (int t = 37; t < 39; t++) run_turn(1, t, "R4 mixed taps per slot");

    // R7: each scale select with random data
    for (int sel = 0; sel < 4; sel++) begin
      cfg_write(NTAPS, sel);
      for (int k = 0; k < NTAPS; k++) cfg_write(k, int'($urandom_range(0, 6000)) - 3000);
      for (int t = 0; t < 3; t++) run_turn(2, t, "R7 scale select");
    end

    // R8: saturation in both directions
    cfg_write(NTAPS, 0);
    for (int k = 0; k < NTAPS; k++) cfg_write(k, 131071);
    for (int t = 0; t < 2; t++) run_turn(3, t, "R8 saturate high");
    for (int t = 0; t < 2; t++) run_turn(4, t, "R8 saturate low");

    // R9: full-scale products that cancel, checked exactly
    cfg_write(NTAPS, 3);
    for (int k = 0; k < NTAPS; k++) cfg_write(k, (k % 2 == 0) ? -131072 : 131071);
    for (int t = 0; t < 33; t++) run_turn(4, t, "R9 exact wide sum");

    repeat (8) @(negedge clk);
    check(q.size() == 0, "R2 every input produced an output", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    done = 1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      check(1'b0, "R2 watchdog expired", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule